// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates six interrupt request groups for a small processor core: external line 0, timer 0 overflow, external line 1, timer 1 overflow, the serial port (receive or transmit) and timer 2 (overflow or external event). A master enable bit and one enable bit per source mask the requests. One priority bit per source places it at the high or the low level. Within a level, a fixed order breaks ties. The block presents one registered request together with the vector address of the winning source.

The core answers a request with a one-cycle acknowledge strobe. That strobe marks the winner's level as in service and clears the flags that hardware owns: the two timer overflow flags and the falling-edge flags of the external lines. A one-cycle return strobe ends the innermost service routine. The two external lines are active low. A per-line type bit selects low-level sensing or falling-edge sensing.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req`, `in_service`, `tmr_flag` and `ext_flag` are all zero.
- R2: While `en_cfg[7]` is 0, `irq_req` stays low in the following cycle, whatever sources are pending.
- R3: With `en_cfg[7]` set, a source requests only while its enable bit is set. The bit positions are: external 0 at bit 0, timer 0 at bit 1, external 1 at bit 2, timer 1 at bit 3, serial at bit 4 and timer 2 at bit 5.
- R4: Among pending sources at the same level, the winner is the first in this order: external 0, timer 0, external 1, timer 1, serial, timer 2. Their vectors are 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R5: `prio_cfg` uses the same bit positions as R3. A 1 places the source at the high level, and a pending high-level source wins over any pending low-level source.
- R6: While the high level is in service, no request is issued. While only the low level is in service, only high-level sources may request.
- R7: `ack` while `irq_req` is high sets `in_service[1]` for a high-level winner or `in_service[0]` for a low-level winner. It also forces `irq_req` low in the next cycle. `ack` while `irq_req` is low changes nothing.
- R8: `reti` clears `in_service[1]` if it is set, otherwise `in_service[0]`.
- R9: With type bit 0, external line i requests while its sampled pin is low. It sets no edge flag, and it requests again after a return if the pin is still low.
- R10: With type bit 1, a high-to-low pin transition sets `ext_flag[i]`. The flag is the request, and acknowledging that line clears it. A pin held low raises no new request.
- R11: A one-cycle `tmr_ovf[i]` pulse sets `tmr_flag[i]`. Acknowledging that timer clears the flag.
- R12: The serial and timer 2 requests follow the `ser_pend` and `t2_pend` inputs and are not cleared by acknowledge. A source still pending after its routine returns requests again.
- R13: A pending source reaches `irq_req` one clock after its flag or sampled pin is registered, so a timer pulse sampled at edge k shows on `irq_req` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_cfg | input | 8 | Bit 7 master enable, bits 5..0 per-source enables |
| prio_cfg | input | 6 | Per-source level, 1 = high |
| ext_pin_n | input | 2 | External request lines, active low |
| ext_type | input | 2 | Per-line sensing: 0 low level, 1 falling edge |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 and timer 1 |
| ser_pend | input | 1 | Serial receive-or-transmit flag, software owned |
| t2_pend | input | 1 | Timer 2 overflow-or-external flag, software owned |
| ack | input | 1 | Vector acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the current request |
| in_service | output | 2 | In-service bits, [1] high level, [0] low level |
| tmr_flag | output | 2 | Timer 0/1 overflow flags |
| ext_flag | output | 2 | External line edge flags |

## Verification
The assertions check these rules on every cycle:
- the master-enable gate;
- the silence while the high level is in service;
- the setting of an in-service bit on acknowledge, with the request dropping;
- the return order when both levels are in service;
- edge capture and timer flag clearing on acknowledge.

Only the bench's scenarios can show the following:
- the full in-level order and its vector values;
- preemption of a low-level routine and its resumption after the return;
- a level-sensed line requesting again;
- software-owned flags surviving an acknowledge;
- the exact request latency.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int unsigned SRC_N = 6;
    localparam int unsigned EXT_N = 2;
    localparam int unsigned IDX_W = $clog2(SRC_N);
    localparam int unsigned LVL_N = 2;

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] idx;
        logic             lvl;
        logic [LVL_N-1:0] insvc;
        logic [EXT_N-1:0] tf;
    } ctl_t;

    typedef struct packed {
        logic pin;
        logic flag;
    } ext_t;
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req,
    output logic flag
);
    ext_t d, q;

    always_comb begin
        d     = q;
        d.pin = pin_n;
        if (edge_mode && q.pin && !pin_n) begin
            d.flag = 1'b1;
        end else if (clr || !edge_mode) begin
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pin: 1'b1, flag: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req  = edge_mode ? q.flag : !q.pin;
    assign flag = q.flag;

    p_edge_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && q.pin && !pin_n) |=> flag);
    p_level_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !flag);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter  int N = 6,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = |cand;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       en_cfg,
    input  logic [SRC_N-1:0] prio_cfg,
    input  logic [EXT_N-1:0] ext_pin_n,
    input  logic [EXT_N-1:0] ext_type,
    input  logic [EXT_N-1:0] tmr_ovf,
    input  logic             ser_pend,
    input  logic             t2_pend,
    input  logic             ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [LVL_N-1:0] in_service,
    output logic [EXT_N-1:0] tmr_flag,
    output logic [EXT_N-1:0] ext_flag
);
    localparam int SER_IDX = 2 * EXT_N;
    localparam int T2_IDX  = 2 * EXT_N + 1;

    ctl_t             d, q;
    logic             take;
    logic [SRC_N-1:0] raw, pend, hi_c, lo_c;
    logic [EXT_N-1:0] ext_req, ext_clr;
    logic             hi_hit, lo_hit;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    assign take = ack && q.req;

    for (genvar i = 0; i < EXT_N; i++) begin : g_ext
        localparam int EXT_IDX = 2 * i;
        localparam int TMR_IDX = 2 * i + 1;
        assign ext_clr[i] = take && (q.idx == IDX_W'(EXT_IDX));
        irq_ext_cond i_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (ext_pin_n[i]),
            .edge_mode(ext_type[i]),
            .clr      (ext_clr[i]),
            .req      (ext_req[i]),
            .flag     (ext_flag[i])
        );
        assign raw[EXT_IDX] = ext_req[i];
        assign raw[TMR_IDX] = q.tf[i];
    end
    assign raw[SER_IDX] = ser_pend;
    assign raw[T2_IDX]  = t2_pend;

    assign pend = raw & en_cfg[SRC_N-1:0] & {SRC_N{en_cfg[7]}};
    assign hi_c = pend & prio_cfg;
    assign lo_c = pend & ~prio_cfg;

    irq_pick #(.N(SRC_N)) i_pick_hi (.cand(hi_c), .hit(hi_hit), .idx(hi_idx));
    irq_pick #(.N(SRC_N)) i_pick_lo (.cand(lo_c), .hit(lo_hit), .idx(lo_idx));

    always_comb begin
        d = q;
        if (reti) begin
            if (q.insvc[1]) begin
                d.insvc[1] = 1'b0;
            end else begin
                d.insvc[0] = 1'b0;
            end
        end
        if (take) begin
            d.insvc[q.lvl] = 1'b1;
        end
        for (int i = 0; i < EXT_N; i++) begin
            if (tmr_ovf[i]) begin
                d.tf[i] = 1'b1;
            end else if (take && (q.idx == IDX_W'(2 * i + 1))) begin
                d.tf[i] = 1'b0;
            end
        end
        if (take) begin
            d.req = 1'b0;
        end else if (!q.insvc[1] && hi_hit) begin
            d.req = 1'b1;
            d.idx = hi_idx;
            d.lvl = 1'b1;
        end else if (q.insvc == '0 && lo_hit) begin
            d.req = 1'b1;
            d.idx = lo_idx;
            d.lvl = 1'b0;
        end else begin
            d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_req    = q.req;
    assign irq_vec    = VEC_W'(VEC_BASE) + VEC_W'(q.idx) * VEC_W'(VEC_STEP);
    assign in_service = q.insvc;
    assign tmr_flag   = q.tf;

    p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cfg[7] |=> !irq_req);
    p_hi_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[1] |=> !irq_req);
    p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !reti) |=> (!irq_req && in_service != '0));
    p_reti_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && in_service == 2'b11) |=> (in_service == 2'b01));
    p_tmr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && irq_vec == VEC_W'(VEC_BASE + VEC_STEP) && !tmr_ovf[0])
        |=> !tmr_flag[0]);
endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  en_cfg;
    logic [5:0]  prio_cfg;
    logic [1:0]  ext_pin_n, ext_type, tmr_ovf;
    logic        ser_pend, t2_pend, ack, reti;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  in_service, tmr_flag, ext_flag;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .en_cfg(en_cfg), .prio_cfg(prio_cfg),
        .ext_pin_n(ext_pin_n), .ext_type(ext_type), .tmr_ovf(tmr_ovf),
        .ser_pend(ser_pend), .t2_pend(t2_pend), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .in_service(in_service),
        .tmr_flag(tmr_flag), .ext_flag(ext_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en_cfg = '0; prio_cfg = '0; ext_pin_n = 2'b11;
        ext_type = 2'b00; tmr_ovf = '0; ser_pend = 0; t2_pend = 0; ack = 0; reti = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(1); reti = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 in_service", in_service, 0);
        chk("R1 tmr_flag", tmr_flag, 0);
        chk("R1 ext_flag", ext_flag, 0);
    endtask

    task automatic t_gate_latency();
        do_reset();
        en_cfg = 8'h02;
        tmr_ovf[0] = 1'b1; step(1); tmr_ovf[0] = 1'b0;
        chk("R11 flag set", tmr_flag[0], 1);
        chk("R13 not yet", irq_req, 0);
        step(1);
        chk("R2 master off", irq_req, 0);
        en_cfg = 8'h80; step(2);
        chk("R3 source off", irq_req, 0);
        en_cfg = 8'h82; step(1);
        chk("R3 source on", irq_req, 1);
        chk("R4 vec t0", irq_vec, 16'h000B);
        pulse_ack();
        chk("R11 flag cleared", tmr_flag[0], 0);
        chk("R7 req dropped", irq_req, 0);
        chk("R7 low in service", in_service, 2'b01);
        pulse_reti();
        chk("R8 low cleared", in_service, 2'b00);
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R7 idle ack ignored", in_service, 2'b00);
    endtask

    task automatic t_order();
        do_reset();
        ext_type = 2'b00; ext_pin_n = 2'b00; ser_pend = 1; t2_pend = 1;
        tmr_ovf = 2'b11; step(1); tmr_ovf = 2'b00;
        en_cfg = 8'hBF; step(2);
        for (int k = 0; k < 6; k++) begin
            chk("R4 order req", irq_req, 1);
            chk("R4 order vec", irq_vec, 32'(3 + 8 * k));
            en_cfg[k] = 1'b0;
            step(1);
        end
        chk("R3 all masked", irq_req, 0);
    endtask

    task automatic t_prio();
        do_reset();
        ext_pin_n[0] = 1'b0; t2_pend = 1; prio_cfg = 6'b100000;
        en_cfg = 8'hA1; step(3);
        chk("R5 high wins", irq_vec, 16'h002B);
        prio_cfg = 6'b000000; step(1);
        chk("R5 back to order", irq_vec, 16'h0003);
    endtask

    task automatic t_nest();
        do_reset();
        en_cfg = 8'hB2; ser_pend = 1; step(1);
        chk("R12 serial req", irq_vec, 16'h0023);
        pulse_ack();
        chk("R7 low marked", in_service, 2'b01);
        step(3);
        chk("R6 same level blocked", irq_req, 0);
        prio_cfg = 6'b100010; t2_pend = 1; step(1);
        chk("R6 preempt req", irq_req, 1);
        chk("R6 preempt vec", irq_vec, 16'h002B);
        pulse_ack();
        chk("R7 high marked", in_service, 2'b11);
        tmr_ovf[0] = 1; step(1); tmr_ovf[0] = 0;
        step(3);
        chk("R6 high blocks high", irq_req, 0);
        t2_pend = 0;
        pulse_reti();
        chk("R8 high first", in_service, 2'b01);
        step(1);
        chk("R6 tf0 after return", irq_vec, 16'h000B);
        pulse_ack();
        chk("R11 tf0 cleared", tmr_flag[0], 0);
        pulse_reti();
        pulse_reti();
        chk("R8 all clear", in_service, 2'b00);
        step(1);
        chk("R12 serial again", irq_req, 1);
        chk("R12 serial vec", irq_vec, 16'h0023);
    endtask

    task automatic t_ext();
        do_reset();
        ext_type = 2'b10; en_cfg = 8'h84; step(1);
        ext_pin_n[1] = 1'b0; step(1);
        chk("R10 edge flag", ext_flag[1], 1);
        step(1);
        chk("R10 vec", irq_vec, 16'h0013);
        pulse_ack();
        chk("R10 flag cleared", ext_flag[1], 0);
        pulse_reti();
        step(3);
        chk("R10 steady low silent", irq_req, 0);
        en_cfg = 8'h81; ext_pin_n[0] = 1'b0; step(2);
        chk("R9 level req", irq_vec, 16'h0003);
        chk("R9 no flag", ext_flag[0], 0);
        pulse_ack();
        pulse_reti();
        step(1);
        chk("R9 re-request", irq_req, 1);
        ext_pin_n[0] = 1'b1; step(2);
        chk("R9 pin released", irq_req, 0);
    endtask

    initial begin
        t_reset();
        t_gate_latency();
        t_order();
        t_prio();
        t_nest();
        t_ext();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule